// File: doc/BRIEF.md
# Single-Pin GPIO Controller with Edge/Level Interrupt

This block controls one general-purpose pin. A 2-bit output source selector picks what drives the pin. The source can be a value written by software, set and clear strobes from software, a value from a streaming DMA source, or set and clear strobes from that DMA source. When set and clear arrive together, set always wins.

On the input side, the pin is brought into the system clock domain and watched for a selectable condition. The condition can be a falling edge, a rising edge, both edges, a low level or a high level. Each is available in a synchronous flavour, which samples the pin first, and most are also available in an asynchronous flavour. For edges, the asynchronous flavour is caught by flops clocked by the pin itself, so pulses shorter than a clock period are still seen. When the condition occurs, a sticky interrupt state bit is set. Software clears it by writing a one to a clear bit. A mask bit gates the interrupt output without touching the state bit.

Software uses a single write word and a single read word, both described in the requirements. Every write updates all configuration fields at once.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: With output source 0 (write bits [4:3]=0), a write copies write bit 0 to `pin_o` after the same clock edge. DMA inputs are ignored in this source.
- R2: With output source 1, write bit 1 sets the output and write bit 2 clears it. When both are set in one write, the output becomes 1. Write bit 0 is ignored in this source.
- R3: With output source 2, `pin_o` takes `dma_val_i` on every clock edge, with or without a write. Software value and strobes are ignored.
- R4: With output source 3, `dma_set_i` sets and `dma_clr_i` clears the output, and set wins when both are high. Software strobes are ignored.
- R5: The read word is laid out as: bit 0 pin output, bits [2:1] output source, bits [6:3] interrupt mode, bit 7 mask, bit 8 pin input after two synchronizer stages, bit 9 interrupt state.
- R6: The synchronous edge modes are written to bits [8:5]: 0 falling, 1 rising, 4 both. Each sets the state bit at the third clock edge after the pin changes, and not before.
- R7: The synchronous level modes are 2 (low) and 3 (high). They set the state bit while the level holds. After a clear, the state reads 0 for one cycle and is set again on the next edge if the level still holds.
- R8: The asynchronous modes are 8 falling, 9 rising, 10 low and 11 high. Modes 8 and 9 catch a pin pulse shorter than one clock period, which the synchronous rising mode misses.
- R9: Mode codes 5, 6, 7 and 12 to 15 never set the state bit.
- R10: Write bit 10 clears the state bit at that edge, and the clear takes precedence over a new event. Write bit 9 is the mask: `irq_o` is the state bit while the mask is 0, and is held at 0 while the mask is 1, with the state bit unchanged.
- R11: Reset gives output 0, output source 0, interrupt mode 0, mask 1 and state 0, so the read word is 0x080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pin_i | input | 1 | Raw pin input level |
| pin_o | output | 1 | Pin output level |
| dma_val_i | input | 1 | DMA output value (source 2) |
| dma_set_i | input | 1 | DMA set strobe (source 3) |
| dma_clr_i | input | 1 | DMA clear strobe (source 3) |
| wr_en_i | input | 1 | Write strobe for the control word |
| wdata_i | input | 11 | Control word |
| rdata_o | output | 10 | Status/readback word |
| irq_o | output | 1 | Masked interrupt output |

## Verification
Output results are due one edge after the write or DMA strobe that causes them, so the bench samples at the falling edge right after that write. Interrupt state appears at the third rising edge after a pin change, for both the synchronous and the asynchronous paths. The bench checks that state is still 0 after two edges and set after three. Input readback is due after two edges. Clear and mask effects are due one edge after their write. Level-mode re-assertion is sampled at both the edge of the clear and the edge after it.

// File: rtl/gpio_pin_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the single-pin GPIO controller.
// Assumes: control/read word layouts below are the software contract.
package gpio_pin_pkg;

    typedef enum logic [1:0] {
        OSRC_REG        = 2'd0,
        OSRC_STROBE     = 2'd1,
        OSRC_DMA_VAL    = 2'd2,
        OSRC_DMA_STROBE = 2'd3
    } osrc_e;

    localparam logic [3:0] IM_S_FALL = 4'd0;
    localparam logic [3:0] IM_S_RISE = 4'd1;
    localparam logic [3:0] IM_S_LOW  = 4'd2;
    localparam logic [3:0] IM_S_HIGH = 4'd3;
    localparam logic [3:0] IM_S_BOTH = 4'd4;
    localparam logic [3:0] IM_A_FALL = 4'd8;
    localparam logic [3:0] IM_A_RISE = 4'd9;
    localparam logic [3:0] IM_A_LOW  = 4'd10;
    localparam logic [3:0] IM_A_HIGH = 4'd11;

    // control word
    localparam int W_VAL   = 0;
    localparam int W_SET   = 1;
    localparam int W_CLR   = 2;
    localparam int W_OSRC  = 3;   // 2 bits
    localparam int W_IMODE = 5;   // 4 bits
    localparam int W_MASK  = 9;
    localparam int W_ICLR  = 10;
    localparam int WR_W    = 11;

    // read word
    localparam int R_OUT   = 0;
    localparam int R_OSRC  = 1;
    localparam int R_IMODE = 3;
    localparam int R_MASK  = 7;
    localparam int R_IN    = 8;
    localparam int R_STATE = 9;
    localparam int RD_W    = 10;

endpackage

// File: rtl/gpio_sync_chain.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for W independent bits.
// Assumes: each bit is a level or toggle that changes slower than the clock.
module gpio_sync_chain #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    // shift the input through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_capture.sv
`timescale 1ns/1ps
// Pin-clocked toggle flops: bit 0 flips on each rising pin edge,
// bit 1 on each falling pin edge. A change of a toggle, seen after
// synchronization, marks one edge even if the pulse was sub-cycle.
// Assumes: reset is applied asynchronously here because the pin is not
// a free-running clock; edges closer than the synchronizer depth merge.
module gpio_edge_capture (
    input  logic       pin_i,
    input  logic       rst_n,
    output logic [1:0] tgl_o
);
    for (genvar e = 0; e < 2; e++) begin : g_edge
        logic t_q;
        if (e == 0) begin : g_rise
            // flip on rising pin edge
            always_ff @(posedge pin_i or negedge rst_n) begin
                if (!rst_n) t_q <= 1'b0;
                else        t_q <= ~t_q;
            end
        end else begin : g_fall
            // flip on falling pin edge
            always_ff @(negedge pin_i or negedge rst_n) begin
                if (!rst_n) t_q <= 1'b0;
                else        t_q <= ~t_q;
            end
        end
        assign tgl_o[e] = t_q;
    end
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
// Interrupt condition decode and sticky state bit.
// Assumes: smp_i is the synchronized pin, tgl_i the synchronized edge
// toggles; a clear in the same cycle as an event wins.
module gpio_irq_detect
    import gpio_pin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_i,
    input  logic [1:0] tgl_i,
    input  logic [3:0] imode_i,
    input  logic       clr_i,
    output logic       state_o
);
    logic       smp_prev;
    logic [1:0] tgl_prev;
    logic       evt;
    logic       mode_ok;
    logic       state_q;

    // remember previous samples for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_prev <= 1'b0;
            tgl_prev <= '0;
        end else begin
            smp_prev <= smp_i;
            tgl_prev <= tgl_i;
        end
    end

    // decode the selected condition
    always_comb begin
        evt     = 1'b0;
        mode_ok = 1'b1;
        case (imode_i)
            IM_S_FALL: evt = ~smp_i & smp_prev;
            IM_S_RISE: evt = smp_i & ~smp_prev;
            IM_S_LOW:  evt = ~smp_i;
            IM_S_HIGH: evt = smp_i;
            IM_S_BOTH: evt = smp_i ^ smp_prev;
            IM_A_FALL: evt = tgl_i[1] ^ tgl_prev[1];
            IM_A_RISE: evt = tgl_i[0] ^ tgl_prev[0];
            IM_A_LOW:  evt = ~smp_i;
            IM_A_HIGH: evt = smp_i;
            default:   mode_ok = 1'b0;
        endcase
    end

    // sticky state: clear first, then set on event
    always_ff @(posedge clk) begin
        if (!rst_n)     state_q <= 1'b0;
        else if (clr_i) state_q <= 1'b0;
        else if (evt)   state_q <= 1'b1;
    end

    assign state_o = state_q;

    AST_UNUSED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q && !mode_ok) |=> !state_q); // R9
    AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !state_q); // R10
endmodule

// File: rtl/gpio_out_sel.sv
`timescale 1ns/1ps
// Output source selection and output register.
// Assumes: a write applies its own source field in the write cycle;
// set beats clear for both software and DMA strobes.
module gpio_out_sel
    import gpio_pin_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_i,
    input  osrc_e wmode_i,
    input  logic  wval_i,
    input  logic  wset_i,
    input  logic  wclr_i,
    input  osrc_e omode_i,
    input  logic  dma_val_i,
    input  logic  dma_set_i,
    input  logic  dma_clr_i,
    output logic  pin_o
);
    osrc_e emode;
    logic  out_q;
    logic  nxt;

    // pick the next output value from the active source
    always_comb begin
        emode = wr_i ? wmode_i : omode_i;
        nxt   = out_q;
        case (emode)
            OSRC_REG:        if (wr_i) nxt = wval_i;
            OSRC_STROBE:     if (wr_i && wset_i) nxt = 1'b1;
                             else if (wr_i && wclr_i) nxt = 1'b0;
            OSRC_DMA_VAL:    nxt = dma_val_i;
            OSRC_DMA_STROBE: if (dma_set_i) nxt = 1'b1;
                             else if (dma_clr_i) nxt = 1'b0;
            default:         nxt = out_q;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= nxt;
    end

    assign pin_o = out_q;

    AST_REG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wmode_i == OSRC_REG) |=> (pin_o == $past(wval_i))); // R1
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wmode_i == OSRC_STROBE && wset_i && wclr_i) |=> pin_o); // R2
    AST_DMA_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_i ? wmode_i : omode_i) == OSRC_DMA_VAL) |=> (pin_o == $past(dma_val_i))); // R3
endmodule

// File: rtl/gpio_pin_ctrl.sv
`timescale 1ns/1ps
// Single-pin GPIO controller: output source select, input
// synchronization, interrupt detection and the control/read words.
// Assumes: every write updates all configuration fields; SYNC_STAGES >= 2.
module gpio_pin_ctrl
    import gpio_pin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_i,
    output logic            pin_o,
    input  logic            dma_val_i,
    input  logic            dma_set_i,
    input  logic            dma_clr_i,
    input  logic            wr_en_i,
    input  logic [WR_W-1:0] wdata_i,
    output logic [RD_W-1:0] rdata_o,
    output logic            irq_o
);
    osrc_e      omode_q;
    logic [3:0] imode_q;
    logic       mask_q;
    logic       pin_smp;
    logic [1:0] tgl_raw;
    logic [1:0] tgl_smp;
    logic       state;
    logic       iclr;

    // configuration register, all fields on every write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            omode_q <= OSRC_REG;
            imode_q <= IM_S_FALL;
            mask_q  <= 1'b1;
        end else if (wr_en_i) begin
            omode_q <= osrc_e'(wdata_i[W_OSRC +: 2]);
            imode_q <= wdata_i[W_IMODE +: 4];
            mask_q  <= wdata_i[W_MASK];
        end
    end

    assign iclr = wr_en_i & wdata_i[W_ICLR];

    gpio_out_sel u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_en_i),
        .wmode_i  (osrc_e'(wdata_i[W_OSRC +: 2])),
        .wval_i   (wdata_i[W_VAL]),
        .wset_i   (wdata_i[W_SET]),
        .wclr_i   (wdata_i[W_CLR]),
        .omode_i  (omode_q),
        .dma_val_i(dma_val_i),
        .dma_set_i(dma_set_i),
        .dma_clr_i(dma_clr_i),
        .pin_o    (pin_o)
    );

    gpio_sync_chain #(.W(1), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (pin_i),
        .q_o  (pin_smp)
    );

    gpio_edge_capture u_cap (
        .pin_i(pin_i),
        .rst_n(rst_n),
        .tgl_o(tgl_raw)
    );

    gpio_sync_chain #(.W(2), .STAGES(SYNC_STAGES)) u_tgl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (tgl_raw),
        .q_o  (tgl_smp)
    );

    gpio_irq_detect u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_i  (pin_smp),
        .tgl_i  (tgl_smp),
        .imode_i(imode_q),
        .clr_i  (iclr),
        .state_o(state)
    );

    assign irq_o = state & ~mask_q;

    // assemble the read word
    always_comb begin
        rdata_o                = '0;
        rdata_o[R_OUT]         = pin_o;
        rdata_o[R_OSRC +: 2]   = omode_q;
        rdata_o[R_IMODE +: 4]  = imode_q;
        rdata_o[R_MASK]        = mask_q;
        rdata_o[R_IN]          = pin_smp;
        rdata_o[R_STATE]       = state;
    end

    AST_MASK_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wdata_i[W_ICLR] && state) |=> state); // R10
endmodule

// File: tb/gpio_pin_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_pin_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_i = 1'b0;
    logic        pin_o;
    logic        dma_val_i = 1'b0;
    logic        dma_set_i = 1'b0;
    logic        dma_clr_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [10:0] wdata_i = '0;
    logic [9:0]  rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_pin_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_o(pin_o),
        .dma_val_i(dma_val_i), .dma_set_i(dma_set_i), .dma_clr_i(dma_clr_i),
        .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    // row: {src[1:0], val, set, clr, dval, dset, dclr, expected}
    localparam logic [8:0] OUT_TBL [14] = '{
        {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    function automatic logic [10:0] mk(logic [1:0] src, logic v, logic s, logic c,
                                       logic [3:0] im, logic m, logic ic);
        return {ic, m, im, src, c, s, v};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [10:0] w);
        wr_en_i = 1'b1;
        wdata_i = w;
        @(negedge clk);
        wr_en_i = 1'b0;
        wdata_i = '0;
    endtask

    task automatic irqw(logic [3:0] im, logic m, logic ic);
        wr(mk(2'd0, 1'b0, 1'b0, 1'b0, im, m, ic));
    endtask

    task automatic waitn(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic glitch();
        pin_i = 1'b1;
        #1;
        pin_i = 1'b0;
    endtask

    function automatic string src_req(logic [1:0] s);
        case (s)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        waitn(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 read word", 32'(rdata_o), 32'h080);
        check("R11 irq", 32'(irq_o), 32'h0);

        // R1..R4 output source table
        foreach (OUT_TBL[i]) begin
            dma_val_i = OUT_TBL[i][3];
            dma_set_i = OUT_TBL[i][2];
            dma_clr_i = OUT_TBL[i][1];
            wr(mk(OUT_TBL[i][8:7], OUT_TBL[i][6], OUT_TBL[i][5], OUT_TBL[i][4],
                  4'd0, 1'b1, 1'b0));
            dma_val_i = 1'b0; dma_set_i = 1'b0; dma_clr_i = 1'b0;
            check(src_req(OUT_TBL[i][8:7]), 32'(pin_o), 32'(OUT_TBL[i][0]));
        end

        // R3 follows DMA value without a write
        wr(mk(2'd2, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0));
        dma_val_i = 1'b1;
        @(negedge clk);
        check("R3 dma follow", 32'(pin_o), 32'h1);
        dma_val_i = 1'b0;
        @(negedge clk);
        check("R3 dma follow low", 32'(pin_o), 32'h0);
        // R5 readback of source field
        check("R5 src field", 32'(rdata_o[2:1]), 32'h2);

        // R6 sync rising, latency
        irqw(4'd1, 1'b1, 1'b1);
        pin_i = 1'b1;
        waitn(2);
        check("R6 rise not early", 32'(rdata_o[9]), 32'h0);
        check("R5 input bit", 32'(rdata_o[8]), 32'h1);
        @(negedge clk);
        check("R6 rise state", 32'(rdata_o[9]), 32'h1);
        check("R10 masked irq", 32'(irq_o), 32'h0);
        irqw(4'd1, 1'b0, 1'b0);
        check("R10 unmasked irq", 32'(irq_o), 32'h1);
        check("R5 mode/mask fields", 32'(rdata_o[7:3]), 32'h01);
        irqw(4'd1, 1'b0, 1'b1);
        check("R10 clear", 32'(rdata_o[9]), 32'h0);
        @(negedge clk);
        check("R10 stays clear", 32'(irq_o), 32'h0);

        // R6 falling
        irqw(4'd0, 1'b1, 1'b1);
        pin_i = 1'b0;
        waitn(3);
        check("R6 fall state", 32'(rdata_o[9]), 32'h1);
        // R6 both edges
        irqw(4'd4, 1'b1, 1'b1);
        pin_i = 1'b1;
        waitn(3);
        check("R6 both rise", 32'(rdata_o[9]), 32'h1);
        irqw(4'd4, 1'b1, 1'b1);
        pin_i = 1'b0;
        waitn(3);
        check("R6 both fall", 32'(rdata_o[9]), 32'h1);

        // R7 high level and re-assert
        irqw(4'd3, 1'b1, 1'b1);
        waitn(3);
        check("R7 high idle", 32'(rdata_o[9]), 32'h0);
        pin_i = 1'b1;
        waitn(3);
        check("R7 high set", 32'(rdata_o[9]), 32'h1);
        irqw(4'd3, 1'b1, 1'b1);
        check("R7 cleared", 32'(rdata_o[9]), 32'h0);
        @(negedge clk);
        check("R7 reassert", 32'(rdata_o[9]), 32'h1);
        // R7 low level
        irqw(4'd2, 1'b1, 1'b1);
        waitn(2);
        check("R7 low idle", 32'(rdata_o[9]), 32'h0);
        pin_i = 1'b0;
        waitn(3);
        check("R7 low set", 32'(rdata_o[9]), 32'h1);

        // R9 unused codes
        irqw(4'd5, 1'b1, 1'b1);
        pin_i = 1'b1; waitn(3); pin_i = 1'b0; waitn(3);
        check("R9 code 5", 32'(rdata_o[9]), 32'h0);
        irqw(4'd12, 1'b1, 1'b1);
        pin_i = 1'b1; waitn(3); pin_i = 1'b0; waitn(3);
        check("R9 code 12", 32'(rdata_o[9]), 32'h0);

        // R8 sub-cycle pulse: sync misses, async catches
        irqw(4'd1, 1'b1, 1'b1);
        glitch();
        waitn(4);
        check("R8 sync misses pulse", 32'(rdata_o[9]), 32'h0);
        irqw(4'd9, 1'b1, 1'b1);
        glitch();
        waitn(3);
        check("R8 async rise", 32'(rdata_o[9]), 32'h1);
        irqw(4'd8, 1'b1, 1'b1);
        glitch();
        waitn(3);
        check("R8 async fall", 32'(rdata_o[9]), 32'h1);
        irqw(4'd11, 1'b1, 1'b1);
        waitn(3);
        check("R8 async high idle", 32'(rdata_o[9]), 32'h0);
        pin_i = 1'b1;
        waitn(3);
        check("R8 async high", 32'(rdata_o[9]), 32'h1);
        irqw(4'd10, 1'b1, 1'b1);
        waitn(2);
        check("R8 async low idle", 32'(rdata_o[9]), 32'h0);
        pin_i = 1'b0;
        waitn(3);
        check("R8 async low", 32'(rdata_o[9]), 32'h1);

        // R11 reset in the middle of activity
        irqw(4'd10, 1'b0, 1'b0);
        check("R10 irq before reset", 32'(irq_o), 32'h1);
        rst_n = 1'b0;
        waitn(2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 read after reset", 32'(rdata_o), 32'h080);
        check("R11 irq after reset", 32'(irq_o), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule